// File: doc/BRIEF.md
# Serial Configuration Register File with Odd Parity

This block is the serial slave front end of a gate-driver controller. A host sends one 16-bit frame per chip-select window, most significant bit first, in SPI mode 0 (clock idles low, data sampled on the rising edge and changed on the falling edge). Each frame carries:

- a register address;
- a write flag;
- a 10-bit data field;
- a parity bit.

Two configuration registers hold the codes that the driver's protection logic uses:

- Register 0 holds the overcurrent filter time code and the dead-time code.
- Register 1 holds the overcurrent threshold code and the low-side drain-source threshold code.

All four codes leave the block as decoded field outputs.

The serial inputs are oversampled in the system clock domain. A frame controller has three states:

- **ST_IDLE**: chip-select high, no frame in progress.
- **ST_SHIFT**: a frame is being received.
- **ST_COMMIT**: a one-cycle decision slot.

The transitions between them are:

- **start** (ST_IDLE to ST_SHIFT): the synchronised chip-select is seen low.
- **end** (ST_SHIFT to ST_COMMIT): the synchronised chip-select is seen high.
- **retire** (ST_COMMIT to ST_IDLE): taken unconditionally.

In ST_COMMIT the frame is judged on its bit count and parity, and a good write updates the addressed register. During every frame the output line returns the addressed register, with the error flag and a freshly computed parity bit.

Top module: `cfg_spi_regfile`

## Requirements
- R1: After reset the outputs hold these values, and the error flag is 0:
  - overcurrent filter time code = 4'b1111
  - dead-time code = 6'b100000
  - overcurrent threshold code = 4'b1001
  - low-side threshold code = 6'b011000
- R2: A frame is laid out as follows:
  - bits [15:12]: address
  - bit [11]: write flag (1 = write, 0 = read)
  - bits [10:7]: the 4-bit code
  - bits [6:1]: the 6-bit code
  - bit [0]: parity
- R2 (continued): Address 0 selects filter time and dead time. Address 1 selects overcurrent threshold and low-side threshold. An accepted write loads the data field into the addressed register. Registers change at no other time.
- R3: A frame of 16 bits whose count of ones over all 16 bits is even is rejected. It changes no register and sets the error flag.
- R4: The error flag is sticky and clears on the next accepted frame, which is a 16-bit frame with odd parity, whether it is a read or a write.
- R5: During a frame the output line shifts out a 16-bit response word, most significant bit first. The response bits are driven after falling clock edges, and the first bit is valid before the first rising edge. The response word is laid out as follows:
  - bits [15:12]: 0
  - bit [11]: the error flag as it stood when the frame began
  - bits [10:1]: the addressed register before this frame's write
  - bit [0]: chosen so that the word holds an odd number of ones
- R6: A frame with any bit count other than 16 when chip-select rises changes neither the registers nor the error flag.
- R7: An address other than 0 or 1 writes nothing, and a read of it returns a zero data field. A good frame to such an address still clears the error flag.
- R8: The output line is low whenever the controller is idle (chip-select high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Asynchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip-select framing one transfer |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| ocp_time_code | output | 4 | Overcurrent filter time code |
| dead_code | output | 6 | Dead-time code |
| ocp_thresh_code | output | 4 | Overcurrent threshold code |
| ls_vds_code | output | 6 | Low-side drain-source threshold code |
| parity_err | output | 1 | Sticky parity error flag |

## Verification
Every serial edge passes two synchroniser stages and one edge-detect register, so the output line changes about three system cycles after a falling serial clock. The bench therefore samples it eight cycles later, just before the next rising edge. Register and error-flag updates land about five cycles after chip-select rises, once the controller has passed through ST_COMMIT. The monitor compares them twenty cycles after the frame ends, and the driver waits forty cycles before it starts the next frame, so no result is read before it is due or after it could be disturbed.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 4;
    localparam int CODE_A_W = 4;
    localparam int CODE_B_W = 6;
    localparam int DATA_W   = CODE_A_W + CODE_B_W;
    localparam int NUM_REGS = 2;
    localparam int RESP_W   = DATA_W + 1;
    localparam int CNT_W    = $clog2(FRAME_W) + 1;
    localparam int ADDR_LSB = FRAME_W - ADDR_W;
    localparam int WR_POS   = ADDR_LSB - 1;
    localparam int DATA_LSB = 1;

    localparam logic [DATA_W-1:0] CFG0_RST = {4'b1111, 6'b100000};
    localparam logic [DATA_W-1:0] CFG1_RST = {4'b1001, 6'b011000};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT
    } frame_state_t;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
    import cfg_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_s,
    input  logic               cs_n_s,
    input  logic               sdi_s,
    input  logic [RESP_W-1:0]  resp_bits,
    output logic [ADDR_W-1:0]  peek_addr,
    output logic               sdo,
    output logic               frame_done,
    output logic               len_ok,
    output logic [FRAME_W-1:0] frame_word,
    output logic               idle
);
    localparam int LOAD_AT = ADDR_W - 1;
    localparam int TX_SKEW = ADDR_W - 1;
    localparam int PAD     = FRAME_W - (RESP_W + 1) - TX_SKEW;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    frame_state_t state, state_nxt;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] rx;
    logic [FRAME_W-1:0] tx;
    logic               sclk_q;
    logic               rise, fall;
    logic [FRAME_W-1:0] tx_load;

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

    // Address is complete at the rising edge that brings in its last bit.
    assign peek_addr = {rx[ADDR_W-2:0], sdi_s};

    // The response is placed so that the next falling edge shows bit 11.
    assign tx_load = {{PAD{1'b0}}, resp_bits, ~^resp_bits, {TX_SKEW{1'b0}}};

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_n_s) state_nxt = ST_SHIFT;
            ST_SHIFT:  if (cs_n_s) state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt    <= '0;
            rx     <= '0;
            tx     <= '0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    rx  <= '0;
                    tx  <= '0;
                end
                ST_SHIFT: begin
                    if (!cs_n_s) begin
                        if (rise) begin
                            rx <= {rx[FRAME_W-2:0], sdi_s};
                            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(LOAD_AT)) tx <= tx_load;
                        end else if (fall) begin
                            tx <= {tx[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
                ST_COMMIT: begin
                    tx <= '0;
                end
                default: begin
                    tx <= '0;
                end
            endcase
        end
    end

    assign sdo        = tx[FRAME_W-1];
    assign frame_done = (state == ST_COMMIT);
    assign len_ok     = (cnt == CNT_W'(FRAME_W));
    assign frame_word = rx;
    assign idle       = (state == ST_IDLE);
endmodule

// File: rtl/cfg_spi_regs.sv
module cfg_spi_regs
    import cfg_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic               len_ok,
    input  logic [FRAME_W-1:0] word,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [RESP_W-1:0]  resp_bits,
    output logic [DATA_W-1:0]  cfg0,
    output logic [DATA_W-1:0]  cfg1,
    output logic               par_err
);
    logic [NUM_REGS-1:0][DATA_W-1:0] bank;
    logic [DATA_W-1:0] rd_data;
    logic              parity_ok, accept, reject, wr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    function automatic logic [DATA_W-1:0] reset_value(int idx);
        return (idx == 0) ? CFG0_RST : CFG1_RST;
    endfunction

    assign parity_ok = ^word;
    assign accept    = commit & len_ok & parity_ok;
    assign reject    = commit & len_ok & ~parity_ok;
    assign wr        = word[WR_POS];
    assign wr_addr   = word[FRAME_W-1:ADDR_LSB];
    assign wr_data   = word[WR_POS-1:DATA_LSB];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int r = 0; r < NUM_REGS; r++) bank[r] <= reset_value(r);
            par_err <= 1'b0;
        end else begin
            if (accept) begin
                par_err <= 1'b0;
                if (wr) begin
                    for (int r = 0; r < NUM_REGS; r++) begin
                        if (wr_addr == ADDR_W'(r)) bank[r] <= wr_data;
                    end
                end
            end else if (reject) begin
                par_err <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_addr == ADDR_W'(r)) rd_data = bank[r];
        end
    end

    assign resp_bits = {par_err, rd_data};
    assign cfg0      = bank[0];
    assign cfg1      = bank[1];
endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
    import cfg_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic [3:0] ocp_time_code,
    output logic [5:0] dead_code,
    output logic [3:0] ocp_thresh_code,
    output logic [5:0] ls_vds_code,
    output logic       parity_err
);
    logic [2:0]         pins_s;
    logic [RESP_W-1:0]  resp_bits;
    logic [ADDR_W-1:0]  peek_addr;
    logic               frame_done, len_ok, idle;
    logic [FRAME_W-1:0] frame_word;
    logic [DATA_W-1:0]  cfg0_q, cfg1_q;

    cfg_spi_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_sclk, spi_cs_n, spi_mosi}),
        .q  (pins_s)
    );

    cfg_spi_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .sdi_s     (pins_s[0]),
        .resp_bits (resp_bits),
        .peek_addr (peek_addr),
        .sdo       (spi_miso),
        .frame_done(frame_done),
        .len_ok    (len_ok),
        .frame_word(frame_word),
        .idle      (idle)
    );

    cfg_spi_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (frame_done),
        .len_ok   (len_ok),
        .word     (frame_word),
        .rd_addr  (peek_addr),
        .resp_bits(resp_bits),
        .cfg0     (cfg0_q),
        .cfg1     (cfg1_q),
        .par_err  (parity_err)
    );

    assign ocp_time_code   = cfg0_q[DATA_W-1:CODE_B_W];
    assign dead_code       = cfg0_q[CODE_B_W-1:0];
    assign ocp_thresh_code = cfg1_q[DATA_W-1:CODE_B_W];
    assign ls_vds_code     = cfg1_q[CODE_B_W-1:0];
endmodule

// File: rtl/cfg_spi_chk.sv
module cfg_spi_chk
    import cfg_spi_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               frame_done,
    input logic               len_ok,
    input logic               idle,
    input logic [FRAME_W-1:0] frame_word,
    input logic [DATA_W-1:0]  cfg0,
    input logic [DATA_W-1:0]  cfg1,
    input logic               par_err,
    input logic               sdo
);
    // R1
    reset_values_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg0 == CFG0_RST && cfg1 == CFG1_RST && !par_err));

    // R2
    only_commit_writes_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> ($stable(cfg0) && $stable(cfg1)));

    // R3
    bad_parity_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && len_ok && !(^frame_word)) |=> ($stable(cfg0) && $stable(cfg1) && par_err));

    // R4
    good_frame_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && len_ok && (^frame_word)) |=> !par_err);

    // R6
    bad_length_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !len_ok) |=> ($stable(cfg0) && $stable(cfg1) && $stable(par_err)));

    // R8
    idle_line_low_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !sdo);
endmodule

bind cfg_spi_regfile cfg_spi_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_done(frame_done),
    .len_ok    (len_ok),
    .idle      (idle),
    .frame_word(frame_word),
    .cfg0      (cfg0_q),
    .cfg1      (cfg1_q),
    .par_err   (parity_err),
    .sdo       (spi_miso)
);

// File: tb/cfg_spi_regfile_test.sv
module cfg_spi_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam logic [9:0] RST0 = 10'b1111_100000;
    localparam logic [9:0] RST1 = 10'b1001_011000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic [3:0] ocp_time_code, ocp_thresh_code;
    logic [5:0] dead_code, ls_vds_code;
    logic parity_err;

    typedef struct {
        string       req;
        logic [9:0]  e0;
        logic [9:0]  e1;
        logic        eerr;
        logic [15:0] esdo;
        logic [15:0] gsdo;
        bit          chk_sdo;
    } exp_t;

    exp_t sb[$];
    event frame_evt;
    int checks = 0;
    int errors = 0;
    logic [9:0] m0 = RST0;
    logic [9:0] m1 = RST1;
    logic merr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_spi_regfile uut (
        .clk            (clk),
        .rst            (rst),
        .spi_sclk       (spi_sclk),
        .spi_cs_n       (spi_cs_n),
        .spi_mosi       (spi_mosi),
        .spi_miso       (spi_miso),
        .ocp_time_code  (ocp_time_code),
        .dead_code      (dead_code),
        .ocp_thresh_code(ocp_thresh_code),
        .ls_vds_code    (ls_vds_code),
        .parity_err     (parity_err)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: sends one frame, updates the model, pushes the expectation.
    task automatic xfer(string req, logic [3:0] addr, logic wr, logic [9:0] data,
                        bit bad_par, int nbits);
        logic [15:0] w;
        logic [15:0] rx;
        logic [9:0]  rd;
        exp_t it;
        w = {addr, wr, data, 1'b0};
        w[0] = (~^w[15:1]) ^ bad_par;
        rd = (addr == 4'd0) ? m0 : (addr == 4'd1) ? m1 : 10'd0;
        it.esdo = {4'b0000, merr, rd, ~^{merr, rd}};
        it.chk_sdo = (nbits >= 16);
        rx = '0;
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(HALF);
            if (i < 16) rx[15-i] = spi_miso;
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        if (nbits == 16) begin
            if (^w) begin
                merr = 1'b0;
                if (wr && addr == 4'd0) m0 = data;
                if (wr && addr == 4'd1) m1 = data;
            end else begin
                merr = 1'b1;
            end
        end
        it.req = req;
        it.e0 = m0;
        it.e1 = m1;
        it.eerr = merr;
        it.gsdo = rx;
        sb.push_back(it);
        ->frame_evt;
        wait_clk(40);
    endtask

    // Monitor: compares outputs against the queued expectation.
    initial begin
        exp_t it;
        forever begin
            @(frame_evt);
            wait_clk(20);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check({it.req, " cfg0"}, {6'b0, ocp_time_code, dead_code}, {6'b0, it.e0});
                check({it.req, " cfg1"}, {6'b0, ocp_thresh_code, ls_vds_code}, {6'b0, it.e1});
                check({it.req, " err R4"}, {15'b0, parity_err}, {15'b0, it.eerr});
                if (it.chk_sdo) check({it.req, " response R5"}, it.gsdo, it.esdo);
                check({it.req, " idle line R8"}, {15'b0, spi_miso}, 16'h0000);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        check("R1 time code", {12'b0, ocp_time_code}, 16'h000F);
        check("R1 dead code", {10'b0, dead_code}, 16'h0020);
        check("R1 threshold code", {12'b0, ocp_thresh_code}, 16'h0009);
        check("R1 low-side code", {10'b0, ls_vds_code}, 16'h0018);
        check("R1 error flag", {15'b0, parity_err}, 16'h0000);
        check("R8 idle after reset", {15'b0, spi_miso}, 16'h0000);

        xfer("R5 read reg0 at reset", 4'd0, 1'b0, 10'h155, 1'b0, 16);
        xfer("R2 write reg0", 4'd0, 1'b1, 10'h2A5, 1'b0, 16);
        xfer("R2 write reg1", 4'd1, 1'b1, 10'h133, 1'b0, 16);
        xfer("R5 read reg1 no write", 4'd1, 1'b0, 10'h3FF, 1'b0, 16);
        xfer("R3 bad parity write", 4'd0, 1'b1, 10'h00F, 1'b1, 16);
        xfer("R4 read shows and clears err", 4'd0, 1'b0, 10'h000, 1'b0, 16);
        xfer("R3 bad parity again", 4'd1, 1'b1, 10'h0AA, 1'b1, 16);
        xfer("R6 short frame", 4'd1, 1'b1, 10'h3C3, 1'b0, 15);
        xfer("R6 long frame", 4'd0, 1'b1, 10'h111, 1'b0, 17);
        xfer("R7 write unmapped", 4'd5, 1'b1, 10'h3FF, 1'b0, 16);
        xfer("R7 read unmapped", 4'd5, 1'b0, 10'h000, 1'b0, 16);
        xfer("R2 write zero codes", 4'd0, 1'b1, 10'h000, 1'b0, 16);
        xfer("R5 read reg0 after zero", 4'd0, 1'b0, 10'h2AA, 1'b0, 16);

        wait_clk(50);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule